// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Write-Back Data Cache

A direct-mapped data cache for a core with 40-bit virtual and 36-bit physical addresses and 4 KiB pages. It has 512 sets of 32-byte lines. The set is picked from virtual address bits 13:5 in the same cycle that a translation unit presents the physical frame number. A hit compares the stored physical tag against that frame number.

Two of the index bits (13 and 12) sit above the page offset, so they are virtual. Because of this, one physical line can occupy two sets under two virtual aliases. The stored tag therefore keeps every physical bit from 35 down to 12. With those bits, a dirty victim's full physical address can be rebuilt from the tag and the in-page index bits (11:5) alone, with no translation at eviction time.

The cache is write-back and write-allocate. A miss writes back a dirty victim first, then fills the line from memory, then completes the request as a hit on the following cycle. A global invalidate drops every line, dirty ones included. Software must clean the cache before using it.

Top module: `vipt_dcache`

## Requirements
- R1: After reset every line is invalid: the first access to any address issues a line fill, issues no writeback, and `mem_req_valid` and `rsp_valid` are low while idle.
- R2: The set index is virtual address bits 13:5. The 32-bit word within the 256-bit line is bits 4:2, and word w occupies line bits 32w+31:32w. Two virtual addresses that differ only in bits 13:12 and translate to the same frame occupy different sets and are both resident at once.
- R3: A hit needs a valid line, `tlb_valid` high, and the stored tag equal to `tlb_pfn`. While `tlb_valid` is low, `req_ready` stays low and no memory request starts.
- R4: A load hit asserts `req_ready` and `rsp_valid` in the cycle the request is presented. In that same cycle `rsp_rdata` holds the addressed word.
- R5: A miss whose victim is clean or invalid issues one read at physical address {`tlb_pfn`, vaddr[11:5], 5'b0}. The cycle after `mem_ack`, the request completes as a hit.
- R6: A miss whose victim is valid and dirty first issues a write of the whole victim line at {stored tag, vaddr[11:5], 5'b0}, and only after its `mem_ack` issues the fill read.
- R7: A store hit writes byte b of `req_wdata` into byte b of the addressed word only where `req_be[b]` is 1, leaves the other bytes unchanged, and marks the line dirty.
- R8: A store miss fills the line first and then merges the store data into it.
- R9: `req_ready` is high only in the response cycle. A memory request keeps its valid, direction and address steady until `mem_ack`.
- R10: `inv_all` while idle clears every valid and dirty bit. The next access to any earlier line misses and issues no writeback, so unwritten stores are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inv_all | input | 1 | Invalidate every line (honoured while idle) |
| req_valid | input | 1 | CPU request present, held until `req_ready` |
| req_write | input | 1 | 1 = store, 0 = load |
| req_vaddr | input | 40 | Virtual byte address |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables, bit b for byte b |
| req_ready | output | 1 | Request completes this cycle |
| rsp_valid | output | 1 | Load data valid this cycle |
| rsp_rdata | output | 32 | Addressed word of the line |
| tlb_valid | input | 1 | Translation result valid |
| tlb_pfn | input | 24 | Physical frame number (PA bits 35:12) |
| mem_req_valid | output | 1 | Memory request active |
| mem_req_write | output | 1 | 1 = writeback, 0 = fill |
| mem_req_addr | output | 36 | Line-aligned physical address |
| mem_req_wdata | output | 256 | Victim line data for a writeback |
| mem_ack | input | 1 | One-cycle completion of the memory request |
| mem_rdata | input | 256 | Fill line data, valid with `mem_ack` |

## Verification
On every cycle the assertions check four things:
- the ready signal stays quiet while the controller is busy or translation is missing;
- memory requests hold steady until acknowledged;
- a writeback is always followed by a fill;
- no line is ever dirty without being valid.

Only the bench's scenarios can show the rest:
- that the rebuilt writeback address matches the frame under which the line was stored;
- that two virtual aliases of one frame coexist in separate sets;
- that byte-enable merging leaves the untouched bytes intact;
- that an invalidate silently drops dirty data.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
    localparam int VA_W    = 40;
    localparam int PA_W    = 36;
    localparam int PAGE_W  = 12;
    localparam int OFF_W   = 5;
    localparam int IDX_W   = 9;
    localparam int WORD_W  = 32;
    localparam int BE_W    = WORD_W / 8;
    localparam int LINE_W  = 8 << OFF_W;
    localparam int SETS    = 1 << IDX_W;
    localparam int TAG_W   = PA_W - PAGE_W;
    localparam int WSEL_W  = OFF_W - $clog2(BE_W);
    localparam int INPG_W  = PAGE_W - OFF_W;

    typedef logic [TAG_W-1:0]  ptag_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [LINE_W-1:0] line_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [WSEL_W-1:0] wsel_t;
    typedef logic [BE_W-1:0]   be_t;
    typedef logic [PA_W-1:0]   paddr_t;

    typedef enum logic [1:0] {ST_IDLE, ST_WB, ST_FILL} st_t;

    function automatic idx_t idx_of(logic [VA_W-1:0] va);
        return va[OFF_W+IDX_W-1:OFF_W];
    endfunction

    function automatic wsel_t wsel_of(logic [VA_W-1:0] va);
        return va[OFF_W-1:OFF_W-WSEL_W];
    endfunction

    // Physical line address from a full physical frame and the in-page index bits.
    function automatic paddr_t pa_line(ptag_t tag, idx_t idx);
        return {tag, idx[INPG_W-1:0], {OFF_W{1'b0}}};
    endfunction

    function automatic word_t word_of(line_t l, wsel_t ws);
        return l[int'(ws)*WORD_W +: WORD_W];
    endfunction

    function automatic line_t merge_word(line_t l, wsel_t ws, word_t d, be_t be);
        line_t r = l;
        for (int b = 0; b < BE_W; b++)
            if (be[b]) r[int'(ws)*WORD_W + b*8 +: 8] = d[b*8 +: 8];
        return r;
    endfunction
endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store
    import vipt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  idx_t  idx,
    input  logic  fill_en,
    input  ptag_t fill_tag,
    input  logic  dirty_en,
    input  logic  inv_en,
    output logic  rd_valid,
    output logic  rd_dirty,
    output ptag_t rd_tag
);
    logic [SETS-1:0] valid_q, dirty_q;
    ptag_t tag_q [SETS];

    always_ff @(posedge clk) begin
        if (rst || inv_en) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (fill_en) begin
                valid_q[idx] <= 1'b1;
                dirty_q[idx] <= 1'b0;
            end
            if (dirty_en) dirty_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) tag_q[idx] <= fill_tag;
    end

    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];
    assign rd_tag   = tag_q[idx];

    AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        (dirty_q & ~valid_q) == '0); // R10
    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid_q == '0)); // R1
endmodule

// File: rtl/vipt_line_store.sv
module vipt_line_store
    import vipt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  idx_t  idx,
    input  logic  fill_en,
    input  line_t fill_line,
    input  logic  st_en,
    input  wsel_t wsel,
    input  word_t wdata,
    input  be_t   be,
    output line_t rd_line
);
    line_t mem_q [SETS];

    always_ff @(posedge clk) begin
        if (fill_en)    mem_q[idx] <= fill_line;
        else if (st_en) mem_q[idx] <= merge_word(mem_q[idx], wsel, wdata, be);
    end

    assign rd_line = mem_q[idx];

    AST_NO_DUAL_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(fill_en && st_en)); // R8
endmodule

// File: rtl/vipt_ctrl.sv
module vipt_ctrl
    import vipt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   inv_all,
    input  logic   req_valid,
    input  logic   req_write,
    input  idx_t   req_idx,
    input  logic   tlb_valid,
    input  ptag_t  tlb_pfn,
    input  logic   rd_valid,
    input  logic   rd_dirty,
    input  ptag_t  rd_tag,
    input  logic   mem_ack,
    output idx_t   look_idx,
    output ptag_t  fill_tag,
    output logic   req_ready,
    output logic   st_en,
    output logic   fill_en,
    output logic   inv_en,
    output logic   mem_req_valid,
    output logic   mem_req_write,
    output paddr_t mem_req_addr
);
    st_t   state_q, state_d;
    idx_t  idx_q;
    ptag_t pfn_q;
    logic  idle, lookup, hit;

    assign idle      = (state_q == ST_IDLE);
    assign lookup    = idle && req_valid && tlb_valid && !inv_all;
    assign hit       = rd_valid && (rd_tag == tlb_pfn);
    assign req_ready = lookup && hit;
    assign st_en     = req_ready && req_write;
    assign inv_en    = idle && inv_all;
    assign look_idx  = idle ? req_idx : idx_q;
    assign fill_tag  = pfn_q;
    assign fill_en   = (state_q == ST_FILL) && mem_ack;

    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        state_d       = state_q;
        case (state_q)
            ST_IDLE: if (lookup && !hit)
                state_d = (rd_valid && rd_dirty) ? ST_WB : ST_FILL;
            ST_WB: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = pa_line(rd_tag, idx_q);
                if (mem_ack) state_d = ST_FILL;
            end
            ST_FILL: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = pa_line(pfn_q, idx_q);
                if (mem_ack) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            pfn_q   <= '0;
        end else begin
            state_q <= state_d;
            if (lookup && !hit) begin
                idx_q <= req_idx;
                pfn_q <= tlb_pfn;
            end
        end
    end

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        !idle |-> !req_ready); // R9
    AST_STALL_NO_TLB: assert property (@(posedge clk) disable iff (rst)
        !tlb_valid |-> !req_ready); // R3
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_ack) |=> (mem_req_valid && $stable(mem_req_addr)
                                         && $stable(mem_req_write))); // R9
    AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write && mem_ack) |=> (mem_req_valid && !mem_req_write)); // R6
    AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0)); // R5
    AST_NO_FILL_WRITE_MIX: assert property (@(posedge clk) disable iff (rst)
        !(fill_en && st_en)); // R8
endmodule

// File: rtl/vipt_dcache.sv
module vipt_dcache
    import vipt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               inv_all,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [WORD_W-1:0]  req_wdata,
    input  logic [BE_W-1:0]    req_be,
    output logic               req_ready,
    output logic               rsp_valid,
    output logic [WORD_W-1:0]  rsp_rdata,
    input  logic               tlb_valid,
    input  logic [TAG_W-1:0]   tlb_pfn,
    output logic               mem_req_valid,
    output logic               mem_req_write,
    output logic [PA_W-1:0]    mem_req_addr,
    output logic [LINE_W-1:0]  mem_req_wdata,
    input  logic               mem_ack,
    input  logic [LINE_W-1:0]  mem_rdata
);
    idx_t  look_idx;
    ptag_t fill_tag, rd_tag;
    line_t rd_line;
    logic  rd_valid, rd_dirty, st_en, fill_en, inv_en;
    logic  unused_va;

    assign unused_va = ^{req_vaddr[VA_W-1:OFF_W+IDX_W], req_vaddr[OFF_W-WSEL_W-1:0]};

    vipt_ctrl u_ctrl (
        .clk, .rst, .inv_all, .req_valid, .req_write,
        .req_idx(idx_of(req_vaddr)), .tlb_valid, .tlb_pfn,
        .rd_valid, .rd_dirty, .rd_tag, .mem_ack,
        .look_idx, .fill_tag, .req_ready, .st_en, .fill_en, .inv_en,
        .mem_req_valid, .mem_req_write, .mem_req_addr
    );

    vipt_tag_store u_tags (
        .clk, .rst, .idx(look_idx), .fill_en, .fill_tag,
        .dirty_en(st_en), .inv_en, .rd_valid, .rd_dirty, .rd_tag
    );

    vipt_line_store u_lines (
        .clk, .rst, .idx(look_idx), .fill_en, .fill_line(mem_rdata),
        .st_en, .wsel(wsel_of(req_vaddr)), .wdata(req_wdata), .be(req_be),
        .rd_line
    );

    assign rsp_valid     = req_ready;
    assign rsp_rdata     = word_of(rd_line, wsel_of(req_vaddr));
    assign mem_req_wdata = rd_line;
endmodule

// File: tb/sim_vipt_dcache.sv
module sim_vipt_dcache;
    logic         clk = 0, rst = 1, inv_all = 0;
    logic         req_valid = 0, req_write = 0;
    logic [39:0]  req_vaddr = '0;
    logic [31:0]  req_wdata = '0;
    logic [3:0]   req_be = '0;
    logic         req_ready, rsp_valid;
    logic [31:0]  rsp_rdata;
    logic         tlb_valid = 0;
    logic [23:0]  tlb_pfn = '0;
    logic         mem_req_valid, mem_req_write;
    logic [35:0]  mem_req_addr;
    logic [255:0] mem_req_wdata;
    logic         mem_ack = 0;
    logic [255:0] mem_rdata = '0;

    int checks = 0, fails = 0, cycles = 0;
    int nfill = 0, nwb = 0;
    logic [35:0] last_fill_addr = '0, last_wb_addr = '0;
    bit fill_after_wb = 0, last_was_wb = 0;

    logic [255:0] truth   [logic [30:0]];
    logic [255:0] backing [logic [30:0]];

    always #5 clk = ~clk;

    vipt_dcache u0 (.*);

    function automatic logic [255:0] init_line(logic [30:0] ln);
        logic [255:0] r;
        for (int w = 0; w < 8; w++) r[w*32 +: 32] = (32'(ln) * 32'h9E3779B1) ^ (32'(w) * 32'h01010101) ^ 32'h5A5A0000;
        return r;
    endfunction

    function automatic logic [255:0] truth_get(logic [30:0] ln);
        return truth.exists(ln) ? truth[ln] : init_line(ln);
    endfunction

    function automatic logic [255:0] back_get(logic [30:0] ln);
        return backing.exists(ln) ? backing[ln] : init_line(ln);
    endfunction

    function automatic logic [23:0] map_pfn(logic [3:0] vpn);
        return 24'h5A0000 | (24'(vpn[3:2]) << 10) | 24'(vpn[1:0]);
    endfunction

    task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory responder: acknowledges on the third cycle of each request
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            mem_ack = 0;
            if (mem_req_valid) begin
                cnt++;
                if (cnt == 3) begin
                    cnt = 0;
                    if (mem_req_write) begin
                        nwb++; last_wb_addr = mem_req_addr; last_was_wb = 1;
                        check(mem_req_wdata == truth_get(mem_req_addr[35:5]), "R6 wb data",
                              mem_req_wdata, truth_get(mem_req_addr[35:5]));
                        backing[mem_req_addr[35:5]] = mem_req_wdata;
                    end else begin
                        nfill++; last_fill_addr = mem_req_addr;
                        fill_after_wb = last_was_wb; last_was_wb = 0;
                        mem_rdata = back_get(mem_req_addr[35:5]);
                    end
                    mem_ack = 1;
                end
            end else cnt = 0;
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected<150000", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    task automatic access(input bit wr, input logic [39:0] va, input logic [23:0] pfn,
                          input logic [31:0] wd, input logic [3:0] be, input string req,
                          output int waited);
        logic [30:0] ln = {pfn, va[11:5]};
        logic [31:0] exp_word;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_vaddr = va; req_wdata = wd; req_be = be;
        tlb_valid = 1; tlb_pfn = pfn; waited = 0;
        #1;
        while (!req_ready && waited < 2000) begin
            @(negedge clk); #1; waited++;
        end
        exp_word = truth_get(ln)[va[4:2]*32 +: 32];
        check(req_ready && rsp_valid, {req, " ready"}, {req_ready, rsp_valid}, 2'b11);
        if (!wr) check(rsp_rdata == exp_word, {req, " load data"}, rsp_rdata, exp_word);
        else begin
            logic [255:0] l = truth_get(ln);
            for (int b = 0; b < 4; b++) if (be[b]) l[va[4:2]*32 + b*8 +: 8] = wd[b*8 +: 8];
            truth[ln] = l;
        end
        @(negedge clk);
        req_valid = 0; tlb_valid = 0;
    endtask

    initial begin
        int w, f0, b0;
        logic [39:0] va, vb;
        logic [23:0] p;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk); #1;
        // R1: idle outputs quiet after reset
        check(!mem_req_valid && !rsp_valid && !req_ready, "R1 reset outputs",
              {mem_req_valid, rsp_valid, req_ready}, 0);

        // R1 R5: first load fills from {pfn, vaddr[11:5], 0}
        va = 40'h00_1234_2044; p = 24'h012342;
        f0 = nfill; b0 = nwb;
        access(0, va, p, 0, 0, "R1", w);
        check(nfill == f0 + 1 && nwb == b0, "R1 one fill no wb", nfill - f0, 1);
        check(last_fill_addr == {p, va[11:5], 5'b0}, "R5 fill addr", last_fill_addr, {p, va[11:5], 5'b0});

        // R4: hit answers in the presenting cycle
        f0 = nfill;
        access(0, va + 40'h8, p, 0, 0, "R4", w);
        check(w == 0 && nfill == f0, "R4 zero-wait hit", w, 0);

        // R3: no translation -> stall
        @(negedge clk);
        req_valid = 1; req_write = 0; req_vaddr = va; tlb_valid = 0; tlb_pfn = p;
        begin
            bit bad = 0;
            repeat (6) begin @(negedge clk); #1; if (req_ready || mem_req_valid) bad = 1; end
            check(!bad, "R3 stall without tlb_valid", bad, 0);
        end
        req_valid = 0;

        // R3: tag mismatch on same set is a miss
        f0 = nfill;
        access(0, va, p ^ 24'h000800, 0, 0, "R3 mismatch", w);
        check(nfill == f0 + 1, "R3 mismatch misses", nfill - f0, 1);
        access(0, va, p, 0, 0, "R3 refill", w);

        // R7: store hit with sparse byte enables
        f0 = nfill;
        access(1, va, p, 32'hDEADBEEF, 4'b0101, "R7", w);
        check(w == 0 && nfill == f0, "R7 store hits", w, 0);
        access(0, va, p, 0, 0, "R7 merged", w);

        // R6: conflicting frame evicts the dirty line with rebuilt address
        f0 = nfill; b0 = nwb;
        access(0, va, p ^ 24'h000100, 0, 0, "R6", w);
        check(nwb == b0 + 1 && nfill == f0 + 1, "R6 wb then fill counts", nwb - b0, 1);
        check(last_wb_addr == {p, va[11:5], 5'b0}, "R6 wb addr", last_wb_addr, {p, va[11:5], 5'b0});
        check(fill_after_wb, "R6 fill follows wb", fill_after_wb, 1);

        // R8: store miss fills then merges
        f0 = nfill;
        access(1, 40'h00_0000_37E0, 24'h0AA003, 32'h11223344, 4'b1111, "R8", w);
        check(nfill == f0 + 1 && w > 0, "R8 store miss fills", nfill - f0, 1);
        access(0, 40'h00_0000_37E0, 24'h0AA003, 0, 0, "R8 readback", w);
        check(w == 0, "R8 merged line hits", w, 0);

        // R2: aliases differing in bits 13:12 live in separate sets
        va = 40'h00_0000_0A40; vb = 40'h00_0000_2A40; p = 24'h0ABC01;
        f0 = nfill;
        access(0, va, p, 0, 0, "R2 alias X", w);
        access(0, vb, p, 0, 0, "R2 alias Y", w);
        check(nfill == f0 + 2, "R2 two fills", nfill - f0, 2);
        f0 = nfill;
        access(0, va, p, 0, 0, "R2 X again", w);
        access(0, vb, p, 0, 0, "R2 Y again", w);
        check(nfill == f0, "R2 both resident", nfill - f0, 0);

        // R10: invalidate drops dirty data without writeback
        va = 40'h00_0000_5100; p = 24'h033301;
        access(1, va, p, 32'hCAFEF00D, 4'b1111, "R10 store", w);
        @(negedge clk); inv_all = 1;
        @(negedge clk); inv_all = 0;
        truth.delete();
        foreach (backing[k]) truth[k] = backing[k];
        f0 = nfill; b0 = nwb;
        access(0, va, p, 0, 0, "R10", w);
        check(nfill == f0 + 1 && nwb == b0, "R10 miss without wb", nwb - b0, 0);

        // random traffic, alias-free mapping
        begin
            int seed = 42;
            void'($urandom(seed));
            for (int i = 0; i < 400; i++) begin
                logic [3:0] vpn = 4'($urandom % 16);
                logic [11:0] off;
                case ($urandom % 3)
                    0: off = 12'h000;
                    1: off = 12'h020;
                    default: off = 12'hFE0;
                endcase
                off[4:2] = 3'($urandom);
                access($urandom % 2, {24'h0, vpn, off}, map_pfn(vpn), $urandom,
                       4'($urandom), "R7 random", w);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule